// File: doc/BRIEF.md
# Address-Match Debug Trigger Unit

This block gives a 32-bit core a small set of hardware breakpoints and watchpoints. Software reaches every trigger through four register slots. The first is an index register that picks the active trigger. The second is that trigger's control word, and the third is its compare value. The fourth is a trigger-enable register that governs machine-mode firing. Each cycle the unit looks at three address strobes from the core: instruction fetch, data load and data store. It also looks at the current privilege level and the debug-mode flag. When an armed trigger's address condition is met, the unit marks that trigger as hit. It then points the index register at that trigger and raises a breakpoint-exception request toward the core.

A trigger compares either the whole address or a naturally aligned power-of-two range. The range size comes from the run of low-order ones in the compare value. Software can write any value to any field. The unit keeps only the encodings it implements, so a read-back shows which capabilities exist. One example is the index register: a write past the last trigger reads back as the number of triggers.

Top module: `addr_trigger_unit`

## Requirements
- R1: After reset the index register reads 0, every compare value reads 0, the trigger-enable register reads 0 and no request is raised. The control word of an implemented trigger reads 0x23E00000: kind 2 in bits 31:28 and the largest range exponent 31 in bits 26:21, with all other bits 0.
- R2: `csr_sel` codes the slots as 0 index, 1 control, 2 compare and 3 trigger-enable. A write to the index register of a value at or above NTRIG makes it read NTRIG. With the index at NTRIG, the control and compare slots read 0 and writes to them change nothing.
- R3: The control word bit positions are as follows.
  - Bit 0 is load, bit 1 is store and bit 2 is fetch.
  - Bit 3 is user mode, bit 4 is supervisor mode and bit 6 is machine mode.
  - Bits 10:7 are the match code and bits 15:12 are the action.
  - Bit 20 is hit and bit 27 is the debug-only lock.
  
  A match code other than 1 reads back 0, and an action other than 1 reads back 0. Bit 4, bits 11, 16 to 19 and bit 5 always read 0.
- R4: With match code 0, a trigger matches only an address equal to its compare value.
- R5: With match code 1, let k be the number of low-order ones in the compare value. The trigger then matches any address whose bits 31:k+1 equal those of the compare value, which is a 2^(k+1)-byte aligned range.
- R6: The fetch, load and store bits enable matching on the fetch, load and store strobes respectively, and each works on its own.
- R7: `priv` is 0 for user, 1 for supervisor and 3 for machine. A trigger fires in user mode only with its user bit set, and in machine mode only with its machine bit set. It never fires in supervisor mode.
- R8: The trigger-enable register has an enable bit (bit 3) and a saved copy (bit 7). Machine-mode firing requires the enable bit. Each firing copies the enable bit into bit 7 and clears bit 3.
- R9: A firing cycle produces the following on the next clock edge.
  - `brk_req` is high for one cycle and `brk_idx` names the lowest-numbered firing trigger.
  - That trigger's hit bit is set.
  - The index register holds its number.
- R10: A trigger whose action reads 1 never fires and never sets its hit bit.
- R11: The lock bit can only be set while `dbg_mode` is high. While a trigger's lock is set, control and compare writes outside debug mode leave it unchanged.
- R12: Writing 0 to a trigger's control word disarms it.
- R13: No trigger fires while `dbg_mode` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register slot: 0 index, 1 control, 2 compare, 3 trigger-enable |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data of the addressed slot (combinational) |
| dbg_mode | input | 1 | Core is in debug mode |
| priv | input | 2 | Current privilege level |
| fetch_vld | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 32 | Fetch address |
| load_vld | input | 1 | Data load strobe |
| load_addr | input | 32 | Load address |
| store_vld | input | 1 | Data store strobe |
| store_addr | input | 32 | Store address |
| brk_req | output | 1 | Breakpoint exception request |
| brk_idx | output | $clog2(NTRIG) | Trigger that caused the request |

## Verification
The embedded properties check several conditions on every cycle.
- The index register never exceeds NTRIG.
- Each request agrees with the index register and with the named trigger's hit bit.
- No request comes out of debug mode, or out of machine mode without the enable bit, and a request always leaves the enable bit cleared.
- A locked trigger's compare value and lock bit survive writes made outside debug mode.

Only the bench's scenarios can show the rest.
- The exact and range matching arithmetic, swept over addresses and range sizes.
- Field legalization and read-back.
- The strobe and privilege enable tables.
- Lowest-index priority over all subsets of triggers.

// File: rtl/addr_trigger_unit.sv
module addr_trigger_unit #(
  parameter int NTRIG  = 4,
  parameter int MAXLOG = 31
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      csr_we,
  input  logic [1:0]                csr_sel,
  input  logic [31:0]               csr_wdata,
  output logic [31:0]               csr_rdata,
  input  logic                      dbg_mode,
  input  logic [1:0]                priv,
  input  logic                      fetch_vld,
  input  logic [31:0]               fetch_addr,
  input  logic                      load_vld,
  input  logic [31:0]               load_addr,
  input  logic                      store_vld,
  input  logic [31:0]               store_addr,
  output logic                      brk_req,
  output logic [$clog2(NTRIG)-1:0]  brk_idx
);
  localparam int IXW = $clog2(NTRIG);
  localparam int SW  = $clog2(NTRIG + 1);
  localparam logic [1:0] A_SEL = 2'd0, A_CTL = 2'd1, A_CMP = 2'd2, A_TCF = 2'd3;

  logic [SW-1:0]    sel_q;
  logic [NTRIG-1:0] ld_q, st_q, ex_q, u_q, m_q, nap_q, act_q, hit_q, dm_q;
  logic [31:0]      cmp_q [NTRIG];
  logic             mte_q, mpte_q;
  logic [NTRIG-1:0] is_sel, fire, win;
  logic [IXW-1:0]   win_idx;
  logic [31:0]      sel_ctl, sel_cmp;
  logic             any_fire, wr_sel, wr_ctl, wr_cmp, wr_tcf;

  assign wr_sel   = csr_we && csr_sel == A_SEL;
  assign wr_ctl   = csr_we && csr_sel == A_CTL;
  assign wr_cmp   = csr_we && csr_sel == A_CMP;
  assign wr_tcf   = csr_we && csr_sel == A_TCF;
  assign win      = fire & (~fire + NTRIG'(1));
  assign any_fire = |fire;

  for (genvar i = 0; i < NTRIG; i++) begin : g_trig
    logic [31:0] ign;
    logic        armed, hf, hl, hs;
    assign is_sel[i] = (sel_q == SW'(i));
    assign ign   = nap_q[i] ? (cmp_q[i] ^ (cmp_q[i] + 32'd1)) : 32'd0;
    assign hf    = fetch_vld & ex_q[i] & (((fetch_addr ^ cmp_q[i]) & ~ign) == 32'd0);
    assign hl    = load_vld  & ld_q[i] & (((load_addr  ^ cmp_q[i]) & ~ign) == 32'd0);
    assign hs    = store_vld & st_q[i] & (((store_addr ^ cmp_q[i]) & ~ign) == 32'd0);
    assign armed = ~act_q[i] & ~dbg_mode &
                   ((priv == 2'b11) ? (m_q[i] & mte_q) :
                    (priv == 2'b00) ? u_q[i] : 1'b0);
    assign fire[i] = armed & (hf | hl | hs);

    p_lock_cmp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmp && is_sel[i] && dm_q[i] && !dbg_mode) |=> $stable(cmp_q[i]));
    p_lock_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && is_sel[i] && dm_q[i] && !dbg_mode) |=> dm_q[i]);
  end

  always_comb begin
    win_idx = '0;
    for (int j = NTRIG - 1; j >= 0; j--)
      if (fire[j]) win_idx = IXW'(j);
  end

  always_comb begin
    sel_ctl = '0;
    sel_cmp = '0;
    for (int j = 0; j < NTRIG; j++)
      if (is_sel[j]) begin
        sel_ctl = {4'd2, dm_q[j], 6'(MAXLOG), hit_q[j], 1'b0, 1'b0, 2'b00,
                   3'b000, act_q[j], 1'b0, 3'b000, nap_q[j], m_q[j], 1'b0,
                   1'b0, u_q[j], ex_q[j], st_q[j], ld_q[j]};
        sel_cmp = cmp_q[j];
      end
  end

  always_comb
    case (csr_sel)
      A_SEL:   csr_rdata = 32'(sel_q);
      A_CTL:   csr_rdata = sel_ctl;
      A_CMP:   csr_rdata = sel_cmp;
      default: csr_rdata = {24'd0, mpte_q, 3'd0, mte_q, 3'd0};
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q   <= '0;
      mte_q   <= 1'b0;
      mpte_q  <= 1'b0;
      brk_req <= 1'b0;
      brk_idx <= '0;
    end else begin
      if (any_fire)    sel_q <= SW'(win_idx);
      else if (wr_sel) sel_q <= (csr_wdata >= 32'(NTRIG)) ? SW'(NTRIG) : csr_wdata[SW-1:0];
      if (any_fire) begin
        mpte_q <= mte_q;
        mte_q  <= 1'b0;
      end else if (wr_tcf) begin
        mte_q  <= csr_wdata[3];
        mpte_q <= csr_wdata[7];
      end
      brk_req <= any_fire;
      brk_idx <= win_idx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ld_q <= '0; st_q <= '0; ex_q <= '0; u_q <= '0; m_q <= '0;
      nap_q <= '0; act_q <= '0; hit_q <= '0; dm_q <= '0;
      for (int j = 0; j < NTRIG; j++) cmp_q[j] <= '0;
    end else begin
      for (int j = 0; j < NTRIG; j++) begin
        if (wr_ctl && is_sel[j] && (!dm_q[j] || dbg_mode)) begin
          ld_q[j]  <= csr_wdata[0];
          st_q[j]  <= csr_wdata[1];
          ex_q[j]  <= csr_wdata[2];
          u_q[j]   <= csr_wdata[3];
          m_q[j]   <= csr_wdata[6];
          nap_q[j] <= (csr_wdata[10:7] == 4'd1);
          act_q[j] <= (csr_wdata[15:12] == 4'd1);
          hit_q[j] <= csr_wdata[20];
          dm_q[j]  <= csr_wdata[27] & dbg_mode;
        end
        if (win[j]) hit_q[j] <= 1'b1;
        if (wr_cmp && is_sel[j] && (!dm_q[j] || dbg_mode)) cmp_q[j] <= csr_wdata;
      end
    end

  p_sel_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q <= SW'(NTRIG));
  p_req_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> sel_q == SW'(brk_idx));
  p_req_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> hit_q[brk_idx]);
  p_mte_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> !mte_q);
  p_mfire_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && $past(priv) == 2'b11) |-> $past(mte_q));
  p_no_dbg_fire_r13: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> !$past(dbg_mode));
  p_no_sup_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(priv) != 2'b01);
endmodule

// File: tb/addr_trigger_unit_tb.sv
`timescale 1ns/1ps
module addr_trigger_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_we = 1'b0;
  logic [1:0] csr_sel = 2'd0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic dbg_mode = 1'b0;
  logic [1:0] priv = 2'd0;
  logic fetch_vld = 1'b0, load_vld = 1'b0, store_vld = 1'b0;
  logic [31:0] fetch_addr = '0, load_addr = '0, store_addr = '0;
  logic brk_req;
  logic [1:0] brk_idx;
  int total = 0, bad = 0, cyc = 0;

  localparam logic [31:0] C_LD = 32'h1, C_ST = 32'h2, C_EX = 32'h4, C_U = 32'h8,
                          C_M = 32'h40, C_NAP = 32'h80, C_LOCK = 32'h0800_0000,
                          C_IDLE = 32'h23E0_0000;

  always #2.5 clk = ~clk;

  addr_trigger_unit dut_i (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .dbg_mode(dbg_mode),
    .priv(priv), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .load_vld(load_vld), .load_addr(load_addr), .store_vld(store_vld),
    .store_addr(store_addr), .brk_req(brk_req), .brk_idx(brk_idx));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual cycles=%0d expected < 150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_w(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_r(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_sel = a;
    #1 d = csr_rdata;
  endtask

  task automatic arm(input int i, input logic [31:0] ctl, input logic [31:0] cmp);
    csr_w(2'd0, 32'(i));
    csr_w(2'd2, cmp);
    csr_w(2'd1, ctl);
  endtask

  task automatic acc(input int kind, input logic [31:0] a, input logic [1:0] p,
                     output logic r, output logic [1:0] ix);
    @(negedge clk);
    priv = p;
    fetch_vld = (kind == 0); fetch_addr = a;
    load_vld  = (kind == 1); load_addr  = a;
    store_vld = (kind == 2); store_addr = a;
    @(negedge clk);
    fetch_vld = 1'b0; load_vld = 1'b0; store_vld = 1'b0;
    #1 r = brk_req; ix = brk_idx;
  endtask

  initial begin
    logic [31:0] d;
    logic r;
    logic [1:0] ix;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 req", 32'(brk_req), 32'd0);
    csr_r(2'd0, d); check("R1 index", d, 32'd0);
    csr_r(2'd1, d); check("R1 control", d, C_IDLE);
    csr_r(2'd2, d); check("R1 compare", d, 32'd0);
    csr_r(2'd3, d); check("R1 enable", d, 32'd0);

    // R2 index legalization
    csr_w(2'd0, 32'hFFFF_FFFF); csr_r(2'd0, d); check("R2 huge index", d, 32'd4);
    csr_w(2'd0, 32'd9);         csr_r(2'd0, d); check("R2 index 9", d, 32'd4);
    csr_w(2'd1, 32'hFFFF_FFFF); csr_r(2'd1, d); check("R2 absent control", d, 32'd0);
    csr_w(2'd2, 32'h1234_5678); csr_r(2'd2, d); check("R2 absent compare", d, 32'd0);
    csr_w(2'd0, 32'd3);         csr_r(2'd0, d); check("R2 index 3", d, 32'd3);
    csr_r(2'd1, d); check("R2 trigger 3 untouched", d, C_IDLE);

    // R3 field legalization
    csr_w(2'd0, 32'd0);
    csr_w(2'd1, 32'hFFFF_FFFF); csr_r(2'd1, d); check("R3 all ones", d, 32'h23F0_004F);
    for (int c = 0; c < 16; c++) begin
      csr_w(2'd1, 32'(c) << 7);  csr_r(2'd1, d);
      check("R3 match code", 32'(d[10:7]), (c == 1) ? 32'd1 : 32'd0);
      csr_w(2'd1, 32'(c) << 12); csr_r(2'd1, d);
      check("R3 action code", 32'(d[15:12]), (c == 1) ? 32'd1 : 32'd0);
    end
    // R12 disarm write
    csr_w(2'd1, 32'd0); csr_r(2'd1, d); check("R12 zero write", d, C_IDLE);

    // R4 exact match
    arm(0, C_EX | C_U, 32'h1000);
    for (int a = 32'hFF8; a <= 32'h1008; a++) begin
      acc(0, 32'(a), 2'd0, r, ix);
      check("R4 exact", 32'(r), (a == 32'h1000) ? 32'd1 : 32'd0);
    end
    // R12 disarm stops firing
    csr_w(2'd0, 32'd0); csr_w(2'd1, 32'd0);
    acc(0, 32'h1000, 2'd0, r, ix); check("R12 disarmed", 32'(r), 32'd0);

    // R5 range match for k = 0..6
    arm(1, C_LD | C_U | C_NAP, 32'h0);
    for (int k = 0; k < 7; k++) begin
      logic [31:0] msk, cmp;
      msk = ~((32'd2 << k) - 32'd1);
      cmp = (32'h2000_0040 & msk) | ((32'd1 << k) - 32'd1);
      csr_w(2'd0, 32'd1); csr_w(2'd2, cmp);
      for (int off = 0; off < 256; off++) begin
        logic [31:0] a;
        a = 32'h2000_0000 + 32'(off);
        acc(1, a, 2'd0, r, ix);
        check("R5 range", 32'(r), ((a & msk) == (cmp & msk)) ? 32'd1 : 32'd0);
      end
    end
    csr_w(2'd0, 32'd1); csr_w(2'd1, 32'd0);

    // R6 access kind enables
    for (int en = 0; en < 8; en++)
      for (int kind = 0; kind < 3; kind++) begin
        logic e;
        arm(0, 32'(en) | C_U, 32'h40);
        e = (kind == 0) ? en[2] : (kind == 1) ? en[0] : en[1];
        acc(kind, 32'h40, 2'd0, r, ix);
        check("R6 kind enable", 32'(r), 32'(e));
      end

    // R7 privilege gating
    for (int um = 0; um < 4; um++)
      for (int pi = 0; pi < 3; pi++) begin
        logic [1:0] p;
        logic e;
        p = (pi == 2) ? 2'd3 : 2'(pi);
        arm(0, C_EX | (um[0] ? C_U : 32'd0) | (um[1] ? C_M : 32'd0), 32'h80);
        csr_w(2'd3, 32'h8);
        e = (p == 2'd0 && um[0]) || (p == 2'd3 && um[1]);
        acc(0, 32'h80, p, r, ix);
        check("R7 privilege", 32'(r), 32'(e));
      end

    // R8 machine enable and saved copy
    arm(0, C_EX | C_M, 32'h90);
    csr_w(2'd3, 32'h0);
    acc(0, 32'h90, 2'd3, r, ix); check("R8 disabled in M", 32'(r), 32'd0);
    csr_w(2'd3, 32'h8);
    acc(0, 32'h90, 2'd3, r, ix); check("R8 enabled in M", 32'(r), 32'd1);
    csr_r(2'd3, d); check("R8 enable saved", d, 32'h80);
    acc(0, 32'h90, 2'd3, r, ix); check("R8 cleared after fire", 32'(r), 32'd0);

    // R9 priority over every subset
    for (int mk = 1; mk < 16; mk++) begin
      int lo;
      lo = 0;
      for (int i = 3; i >= 0; i--) if (mk[i]) lo = i;
      for (int i = 0; i < 4; i++) arm(i, mk[i] ? (C_EX | C_U) : 32'd0, 32'h500);
      acc(0, 32'h500, 2'd0, r, ix);
      check("R9 request", 32'(r), 32'd1);
      check("R9 index", 32'(ix), 32'(lo));
      csr_r(2'd0, d); check("R9 select loaded", d, 32'(lo));
      csr_r(2'd1, d); check("R9 hit set", 32'(d[20]), 32'd1);
      for (int i = 0; i < 4; i++)
        if (mk[i] && i != lo) begin
          csr_w(2'd0, 32'(i)); csr_r(2'd1, d);
          check("R9 loser hit clear", 32'(d[20]), 32'd0);
        end
    end
    for (int i = 0; i < 4; i++) arm(i, 32'd0, 32'd0);

    // R10 action 1 never fires
    arm(2, C_EX | C_U | 32'h1000, 32'h600);
    acc(0, 32'h600, 2'd0, r, ix); check("R10 no request", 32'(r), 32'd0);
    csr_r(2'd1, d); check("R10 no hit", 32'(d[20]), 32'd0);
    csr_w(2'd1, 32'd0);

    // R11 debug-only lock
    csr_w(2'd0, 32'd3);
    csr_w(2'd1, C_LOCK | C_LD); csr_r(2'd1, d);
    check("R11 lock from M", 32'(d[27]), 32'd0);
    dbg_mode = 1'b1;
    csr_w(2'd2, 32'h700);
    csr_w(2'd1, C_LOCK | C_LD); csr_r(2'd1, d);
    check("R11 lock from debug", 32'(d[27]), 32'd1);
    // R13 no firing in debug mode
    csr_w(2'd1, C_LOCK | C_LD | C_U);
    acc(1, 32'h700, 2'd0, r, ix); check("R13 debug suppress", 32'(r), 32'd0);
    dbg_mode = 1'b0;
    csr_w(2'd1, 32'd0);          csr_r(2'd1, d);
    check("R11 locked control", d, C_IDLE | C_LOCK | C_LD | C_U);
    csr_w(2'd2, 32'h1);          csr_r(2'd2, d);
    check("R11 locked compare", d, 32'h700);
    dbg_mode = 1'b1;
    csr_w(2'd1, 32'd0); csr_r(2'd1, d);
    check("R11 debug unlock", d, C_IDLE);
    dbg_mode = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule